// File: doc/BRIEF.md
# Control Network Packet Send Port

This block lets a processor put fixed-size packets onto a control network through a few memory-mapped registers. Software first writes a header register that holds the route and the tag. It then writes a 64-bit payload to one of two send registers. That write is itself the send command: the port builds a packet from the stored header and the written payload and offers it to the router.

The two send registers differ in one thing only. The address that was written selects the end-of-transfer flag of the outgoing packet. The header stays in place after each send, so a stream of payloads can share one route and tag. The port adds no rate regulation of its own.

Only one packet can be held at a time. While that packet has not been accepted, a new payload write is held off with a stall signal. It is not dropped, and the processor repeats it on the next cycle. If the router accepts the held packet in the same cycle as a payload write, the new packet is taken with no idle cycle in between.

Top module: `ctlTxPort`

## Requirements
- R1: After reset, `pktValid` is 0 and reading address 0 returns zero.
- R2: A write to address 0 stores route = `regWrData[ROUTE_W-1:0]` and tag = `regWrData[ROUTE_W+TAG_W-1:ROUTE_W]`. From the next cycle, reading address 0 (`regRdData` is combinational on `regAddr`) returns these bits zero-extended to 64 bits.
- R3: A write to address 1 that is not stalled makes `pktValid` 1 on the next cycle. The packet carries the written payload, the stored route and tag, and `pktEot` = 1.
- R4: A write to address 2 that is not stalled sends a packet in the same way, with `pktEot` = 0.
- R5: The header register keeps its value across sends, so successive payload writes use the same route and tag.
- R6: While `pktValid` is 1 and `pktReady` is 0, the port keeps `pktValid` at 1 and keeps route, tag, end-of-transfer and payload unchanged.
- R7: A payload write (address 1 or 2) in a cycle where `pktValid` is 1 and `pktReady` is 0 raises `regStall` in that same cycle and has no effect.
- R8: A payload write in a cycle where `pktValid` and `pktReady` are both 1 is not stalled. The new packet is valid on the very next cycle.
- R9: When `pktValid` and `pktReady` are both 1 and no payload write occurs, `pktValid` is 0 on the next cycle.
- R10: A write to address 3 has no effect on the header or the packet output. Reading any address other than 0 returns zero.
- R11: A header write while a packet is pending leaves that packet's route and tag unchanged. Only later sends use the new header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address: 0 header, 1 send with end-of-transfer, 2 send without, 3 unused |
| regWrData | input | 64 | Register write data |
| regRdData | output | 64 | Header read-back at address 0, zero elsewhere |
| regStall | output | 1 | Payload write refused this cycle; repeat it |
| pktValid | output | 1 | Outgoing packet is valid |
| pktReady | input | 1 | Router accepts the packet |
| pktRoute | output | ROUTE_W | Route field of the packet |
| pktTag | output | TAG_W | Tag field of the packet |
| pktEot | output | 1 | End-of-transfer flag of the packet |
| pktPayload | output | 64 | Packet payload |

## Verification
Two functions can fall in the same clock edge: the router draining the held packet, and a processor payload write loading the next packet. The bench provokes this by issuing a payload write while a packet is pending, with `pktReady` set in one case and cleared in the other. In the first case it expects no stall and a new packet on the next cycle with no gap. In the second it expects a stall and an unchanged held packet. A behavioural model, compared every cycle, also judges the random traffic that mixes both events with header writes.

// File: rtl/ctlTxPkg.sv
package ctlTxPkg;
  localparam int PAY_W  = 64;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_HDR      = 2'd0,
    ADDR_PAY_EOT  = 2'd1,
    ADDR_PAY_CONT = 2'd2,
    ADDR_SPARE    = 2'd3
  } regAddr_e;

  // strobes from control to datapath
  typedef struct packed {
    logic hdrLoad;
    logic pktLoad;
    logic eotVal;
  } txStrobe_t;
endpackage

// File: rtl/ctlTxCtrl.sv
module ctlTxCtrl
  import ctlTxPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              pktReady,
  output txStrobe_t         strobe,
  output logic              regStall,
  output logic              pktValid
);
  regAddr_e addrE;
  logic     wrHdr;
  logic     wrPay;
  logic     validQ;

  always_comb begin
    addrE           = regAddr_e'(regAddr);
    wrHdr           = regWrEn && (addrE == ADDR_HDR);
    wrPay           = regWrEn && ((addrE == ADDR_PAY_EOT) || (addrE == ADDR_PAY_CONT));
    regStall        = wrPay && validQ && !pktReady;
    strobe.hdrLoad  = wrHdr;
    strobe.pktLoad  = wrPay && !regStall;
    strobe.eotVal   = (addrE == ADDR_PAY_EOT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= 1'b0;
    end else if (strobe.pktLoad) begin
      validQ <= 1'b1;
    end else if (pktReady) begin
      validQ <= 1'b0;
    end
  end

  assign pktValid = validQ;
endmodule

// File: rtl/ctlTxDatapath.sv
module ctlTxDatapath
  import ctlTxPkg::*;
#(
  parameter int ROUTE_W = 32,
  parameter int TAG_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  txStrobe_t          strobe,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [PAY_W-1:0]   regWrData,
  output logic [PAY_W-1:0]   regRdData,
  output logic [ROUTE_W-1:0] pktRoute,
  output logic [TAG_W-1:0]   pktTag,
  output logic               pktEot,
  output logic [PAY_W-1:0]   pktPayload
);
  localparam int HDR_W = ROUTE_W + TAG_W;

  logic [HDR_W-1:0] hdrQ;
  logic [PAY_W-1:0] hdrWide;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hdrQ <= '0;
    end else if (strobe.hdrLoad) begin
      hdrQ <= regWrData[HDR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pktRoute   <= '0;
      pktTag     <= '0;
      pktEot     <= 1'b0;
      pktPayload <= '0;
    end else if (strobe.pktLoad) begin
      pktRoute   <= hdrQ[ROUTE_W-1:0];
      pktTag     <= hdrQ[HDR_W-1:ROUTE_W];
      pktEot     <= strobe.eotVal;
      pktPayload <= regWrData;
    end
  end

  generate
    if (HDR_W < PAY_W) begin : g_pad
      assign hdrWide = {{(PAY_W-HDR_W){1'b0}}, hdrQ};
    end else begin : g_full
      assign hdrWide = hdrQ[PAY_W-1:0];
    end
  endgenerate

  always_comb begin
    regRdData = (regAddr_e'(regAddr) == ADDR_HDR) ? hdrWide : '0;
  end
endmodule

// File: rtl/ctlTxPort.sv
module ctlTxPort #(
  parameter int ROUTE_W = 32,
  parameter int TAG_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [1:0]         regAddr,
  input  logic [63:0]        regWrData,
  output logic [63:0]        regRdData,
  output logic               regStall,
  output logic               pktValid,
  input  logic               pktReady,
  output logic [ROUTE_W-1:0] pktRoute,
  output logic [TAG_W-1:0]   pktTag,
  output logic               pktEot,
  output logic [63:0]        pktPayload
);
  ctlTxPkg::txStrobe_t strobe;

  ctlTxCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .pktReady (pktReady),
    .strobe   (strobe),
    .regStall (regStall),
    .pktValid (pktValid)
  );

  ctlTxDatapath #(.ROUTE_W(ROUTE_W), .TAG_W(TAG_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .pktRoute   (pktRoute),
    .pktTag     (pktTag),
    .pktEot     (pktEot),
    .pktPayload (pktPayload)
  );
endmodule

// File: rtl/ctlTxPort_chk.sv
module ctlTxPort_chk #(
  parameter int ROUTE_W = 32,
  parameter int TAG_W   = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               regWrEn,
  input logic [1:0]         regAddr,
  input logic [63:0]        regWrData,
  input logic               regStall,
  input logic               pktValid,
  input logic               pktReady,
  input logic [ROUTE_W-1:0] pktRoute,
  input logic [TAG_W-1:0]   pktTag,
  input logic               pktEot,
  input logic [63:0]        pktPayload
);
  logic payWr;
  assign payWr = regWrEn && ((regAddr == 2'd1) || (regAddr == 2'd2));

  a_r6_hold_packet: assert property (@(posedge clk) disable iff (!rstN)
    pktValid && !pktReady |=> pktValid && $stable(pktPayload) && $stable(pktRoute)
                              && $stable(pktTag) && $stable(pktEot));

  a_r7_stall_only_when_blocked: assert property (@(posedge clk) disable iff (!rstN)
    regStall |-> payWr && pktValid && !pktReady);

  a_r3_send_with_eot: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && regAddr == 2'd1 && !regStall |=> pktValid && pktEot && pktPayload == $past(regWrData));

  a_r4_send_without_eot: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && regAddr == 2'd2 && !regStall |=> pktValid && !pktEot && pktPayload == $past(regWrData));

  a_r8_no_stall_on_accept: assert property (@(posedge clk) disable iff (!rstN)
    pktValid && pktReady |-> !regStall);

  a_r9_drain: assert property (@(posedge clk) disable iff (!rstN)
    pktValid && pktReady && !payWr |=> !pktValid);
endmodule

bind ctlTxPort ctlTxPort_chk #(.ROUTE_W(ROUTE_W), .TAG_W(TAG_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regWrEn    (regWrEn),
  .regAddr    (regAddr),
  .regWrData  (regWrData),
  .regStall   (regStall),
  .pktValid   (pktValid),
  .pktReady   (pktReady),
  .pktRoute   (pktRoute),
  .pktTag     (pktTag),
  .pktEot     (pktEot),
  .pktPayload (pktPayload)
);

// File: tb/ctlTxPort_bench.sv
`timescale 1ns/1ps
module ctlTxPort_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn;
  logic [1:0]  regAddr;
  logic [63:0] regWrData;
  logic [63:0] regRdData;
  logic        regStall;
  logic        pktValid;
  logic        pktReady;
  logic [31:0] pktRoute;
  logic [7:0]  pktTag;
  logic        pktEot;
  logic [63:0] pktPayload;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [39:0] mHdr;
  logic [39:0] mHdrOut;
  logic        mValid;
  logic [63:0] mPay;
  logic        mEot;

  always #5 clk = ~clk;

  ctlTxPort u_ctlTxPort (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .regStall(regStall),
    .pktValid(pktValid), .pktReady(pktReady), .pktRoute(pktRoute),
    .pktTag(pktTag), .pktEot(pktEot), .pktPayload(pktPayload)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input string req, input logic we, input logic [1:0] a,
                      input logic [63:0] d, input logic rdy);
    logic payW;
    logic expStall;
    regWrEn = we; regAddr = a; regWrData = d; pktReady = rdy;
    #1;
    payW     = we && (a == 2'd1 || a == 2'd2);
    expStall = payW && mValid && !rdy;
    check(req, "regStall", {63'h0, regStall}, {63'h0, expStall});
    check(req, "regRdData", regRdData, (a == 2'd0) ? {24'h0, mHdr} : 64'h0);
    @(posedge clk);
    if (payW && !expStall) begin
      mValid = 1'b1; mPay = d; mHdrOut = mHdr; mEot = (a == 2'd1);
    end else if (rdy) begin
      mValid = 1'b0;
    end
    if (we && a == 2'd0) mHdr = d[39:0];
    @(negedge clk);
    check(req, "pktValid", {63'h0, pktValid}, {63'h0, mValid});
    if (mValid) begin
      check(req, "pktPayload", pktPayload, mPay);
      check(req, "pktRoute", {32'h0, pktRoute}, {32'h0, mHdrOut[31:0]});
      check(req, "pktTag", {56'h0, pktTag}, {56'h0, mHdrOut[39:32]});
      check(req, "pktEot", {63'h0, pktEot}, {63'h0, mEot});
    end
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    mHdr = '0; mHdrOut = '0; mValid = 1'b0; mPay = '0; mEot = 1'b0;
    rstN = 1'b0; regWrEn = 1'b0; regAddr = 2'd0; regWrData = '0; pktReady = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    step("R1", 1'b0, 2'd0, 64'h0, 1'b1);
    // R2: header store and read-back
    step("R2", 1'b1, 2'd0, 64'hFFFF_FF12_DEAD_BEEF, 1'b1);
    step("R2", 1'b0, 2'd0, 64'h0, 1'b0);
    // R3: send with end-of-transfer, router not ready
    step("R3", 1'b1, 2'd1, 64'h1111_2222_3333_4444, 1'b0);
    // R6: held stable
    step("R6", 1'b0, 2'd0, 64'h0, 1'b0);
    // R7: blocked write stalls
    step("R7", 1'b1, 2'd2, 64'hAAAA_BBBB_CCCC_DDDD, 1'b0);
    // R8: repeated write while router accepts
    step("R8", 1'b1, 2'd2, 64'hAAAA_BBBB_CCCC_DDDD, 1'b1);
    // R4 / R5: no end-of-transfer, same header
    step("R4", 1'b0, 2'd1, 64'h0, 1'b0);
    step("R5", 1'b0, 2'd0, 64'h0, 1'b0);
    // R11: header write while packet pending
    step("R11", 1'b1, 2'd0, 64'h0000_0077_0BAD_F00D, 1'b0);
    step("R11", 1'b0, 2'd0, 64'h0, 1'b0);
    // R9: drain with no write
    step("R9", 1'b0, 2'd3, 64'h0, 1'b1);
    step("R9", 1'b0, 2'd0, 64'h0, 1'b1);
    // R10: unused address write and reads elsewhere
    step("R10", 1'b1, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    step("R10", 1'b0, 2'd1, 64'h0, 1'b1);
    step("R10", 1'b0, 2'd2, 64'h0, 1'b1);
    step("R10", 1'b0, 2'd0, 64'h0, 1'b1);
    // R11: later send uses new header
    step("R11", 1'b1, 2'd1, 64'h5555_6666_7777_8888, 1'b0);
    step("R11", 1'b0, 2'd0, 64'h0, 1'b1);
    // mixed traffic
    lfsr = 32'h1ACE_B00C;
    for (int i = 0; i < 200; i++) begin
      lfsr = lfsr * 32'd1103515245 + 32'd12345;
      step("R8", lfsr[20], lfsr[17:16], {lfsr, ~lfsr}, lfsr[24] | lfsr[27]);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule